// File: doc/BRIEF.md
# Sliding-Window Context Probability Updater

This block adapts one binary context model after every decoded bin of an arithmetic decoder. A context is a 10-bit log-domain probability of the most probable symbol, a 2-bit saturating age counter and the current most-probable-symbol value. The caller reads a context from its own storage and presents it with a flag that says whether the decoded bin matched the most probable symbol. One cycle later the block returns the updated triple with a valid strobe, ready to be written back.

The adaptation speed depends on the age counter. A young context uses a narrow window, so it adapts quickly. An older context uses wider windows, so it adapts more slowly. When the bin matches the most probable symbol, the log-probability decays by two right-shifted copies of itself. When the bin does not match, a window-dependent constant is added to it. If that sum leaves the 10-bit range, the value is reflected back into range and the most-probable-symbol value is inverted.

Top module: `ctx_prob_adapt`

## Requirements
- R1: While reset is asserted and after it is released with no input strobe, `out_valid` is 0, `out_lgp` is 1023, `out_cyc` is 0 and `out_mps_val` is 0 (the fresh-slice context).
- R2: `out_valid` is 1 in exactly the cycle after a cycle in which `in_valid` was 1, and 0 otherwise.
- R3: The window width w is taken from the input age value before it is incremented: w = 3 for age 0 or 1, w = 4 for age 2 and w = 5 for age 3.
- R4: For every strobed update, `out_cyc` is the input age plus one when the input age is 0, 1 or 2, and stays 3 when the input age is 3. This holds for both bin kinds.
- R5: When `in_is_mps` is 1, `out_lgp` = p − (p >> w) − (p >> (w+2)), where p is `in_lgp`, and `out_mps_val` equals `in_mps_val`.
- R6: When `in_is_mps` is 0 and p + s ≤ 1023, where s is 197 for w = 3, 95 for w = 4 and 46 for w = 5, `out_lgp` = p + s and `out_mps_val` equals `in_mps_val`.
- R7: When `in_is_mps` is 0 and p + s > 1023, `out_lgp` = 2047 − (p + s) and `out_mps_val` is the inverse of `in_mps_val`.
- R8: In a cycle with `in_valid` 0, the registered outputs keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: a context and bin result are presented |
| in_is_mps | input | 1 | 1 when the decoded bin equals the most probable symbol |
| in_lgp | input | 10 | Current log-probability of the most probable symbol |
| in_cyc | input | 2 | Current saturating age counter |
| in_mps_val | input | 1 | Current most-probable-symbol value |
| out_valid | output | 1 | Strobe: updated context is on the outputs |
| out_lgp | output | 10 | Updated log-probability |
| out_cyc | output | 2 | Updated age counter |
| out_mps_val | output | 1 | Updated most-probable-symbol value |

## Verification
The bench applies every combination of the 1024 log-probability values, the four age values, both bin kinds and both symbol values back to back, so every strobe is followed by another. The match sweep over all four ages separates the three window widths, because a wrong width gives a different decay for almost every p. The mismatch sweep crosses the overflow boundary for each step constant, which separates plain addition from reflection and symbol inversion at p + s = 1023 and 1024. A final stretch with the strobe low and changing inputs shows whether the registers hold and whether the valid strobe drops.

// File: rtl/ctxp_pkg.sv
package ctxp_pkg;

   // Window class chosen from the age counter
   typedef enum logic [1:0] {
      WIN_NARROW = 2'd0,
      WIN_MID    = 2'd1,
      WIN_WIDE   = 2'd2
   } win_e;

   // Decay datapath variants
   localparam int DECAY_BARREL = 0;
   localparam int DECAY_SLICED = 1;

endpackage

// File: rtl/ctxp_window.sv
module ctxp_window
   import ctxp_pkg::*;
#(
   parameter int CYC_W      = 2,
   parameter int NARROW_MAX = 1,
   parameter int MID_AGE    = 2
) (
   input  logic [CYC_W-1:0] age_i,
   output win_e             win_o,
   output logic [CYC_W-1:0] age_next_o
);
   localparam int               AGE_MAX   = (1 << CYC_W) - 1;
   localparam logic [CYC_W-1:0] AGE_TOP   = CYC_W'(AGE_MAX);
   localparam logic [CYC_W-1:0] AGE_NMAX  = CYC_W'(NARROW_MAX);
   localparam logic [CYC_W-1:0] AGE_MIDV  = CYC_W'(MID_AGE);

   generate
      if (CYC_W < 2) begin : g_bad_cyc
         $error("ctxp_window: CYC_W must be at least 2");
      end
      if (!(NARROW_MAX < MID_AGE && MID_AGE < AGE_MAX)) begin : g_bad_ages
         $error("ctxp_window: thresholds must satisfy NARROW_MAX < MID_AGE < top age");
      end
   endgenerate

   // Window class uses the age before it advances
   always_comb begin
      if (age_i <= AGE_NMAX)      win_o = WIN_NARROW;
      else if (age_i == AGE_MIDV) win_o = WIN_MID;
      else                        win_o = WIN_WIDE;
   end

   // Saturating age advance
   always_comb begin
      if (age_i == AGE_TOP) age_next_o = AGE_TOP;
      else                  age_next_o = age_i + CYC_W'(1);
   end

endmodule

// File: rtl/ctxp_mps_decay.sv
module ctxp_mps_decay
   import ctxp_pkg::*;
#(
   parameter int PROB_W     = 10,
   parameter int SH_NARROW  = 3,
   parameter int SH_MID     = 4,
   parameter int SH_WIDE    = 5,
   parameter int TAIL_EXTRA = 2,
   parameter int IMPL       = DECAY_SLICED
) (
   input  logic [PROB_W-1:0] lgp_i,
   input  win_e              win_i,
   output logic [PROB_W-1:0] lgp_o
);
   localparam int SH_W = $clog2(PROB_W + 1);

   generate
      if (SH_WIDE + TAIL_EXTRA >= PROB_W) begin : g_bad_shift
         $error("ctxp_mps_decay: widest shift leaves no bits");
      end
      if (!(SH_NARROW < SH_MID && SH_MID < SH_WIDE)) begin : g_bad_order
         $error("ctxp_mps_decay: shifts must grow with the window");
      end
      if (IMPL != DECAY_BARREL && IMPL != DECAY_SLICED) begin : g_bad_impl
         $error("ctxp_mps_decay: unknown IMPL");
      end
   endgenerate

   generate
      if (IMPL == DECAY_BARREL) begin : g_barrel
         // One shared pair of variable shifters
         logic [SH_W-1:0] sh_a;
         logic [SH_W-1:0] sh_b;
         always_comb begin
            case (win_i)
               WIN_NARROW: sh_a = SH_W'(SH_NARROW);
               WIN_MID:    sh_a = SH_W'(SH_MID);
               default:    sh_a = SH_W'(SH_WIDE);
            endcase
            sh_b = sh_a + SH_W'(TAIL_EXTRA);
         end
         assign lgp_o = lgp_i - (lgp_i >> sh_a) - (lgp_i >> sh_b);
      end else begin : g_sliced
         // Three fixed-slice candidates, selected after the subtraction
         logic [PROB_W-1:0] cand_n;
         logic [PROB_W-1:0] cand_m;
         logic [PROB_W-1:0] cand_w;
         assign cand_n = lgp_i - (lgp_i >> SH_NARROW) - (lgp_i >> (SH_NARROW + TAIL_EXTRA));
         assign cand_m = lgp_i - (lgp_i >> SH_MID)    - (lgp_i >> (SH_MID + TAIL_EXTRA));
         assign cand_w = lgp_i - (lgp_i >> SH_WIDE)   - (lgp_i >> (SH_WIDE + TAIL_EXTRA));
         always_comb begin
            case (win_i)
               WIN_NARROW: lgp_o = cand_n;
               WIN_MID:    lgp_o = cand_m;
               default:    lgp_o = cand_w;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/ctxp_lps_step.sv
module ctxp_lps_step
   import ctxp_pkg::*;
#(
   parameter int PROB_W      = 10,
   parameter int STEP_NARROW = 197,
   parameter int STEP_MID    = 95,
   parameter int STEP_WIDE   = 46
) (
   input  logic [PROB_W-1:0] lgp_i,
   input  win_e              win_i,
   input  logic              mps_val_i,
   output logic [PROB_W-1:0] lgp_o,
   output logic              mps_val_o
);
   localparam int SUM_W = PROB_W + 1;
   localparam logic [SUM_W-1:0] MIRROR = {SUM_W{1'b1}};

   generate
      if (STEP_NARROW >= (1 << PROB_W) || STEP_MID >= (1 << PROB_W) ||
          STEP_WIDE >= (1 << PROB_W)) begin : g_bad_step
         $error("ctxp_lps_step: step constants must fit below full scale");
      end
      if (STEP_NARROW <= 0 || STEP_MID <= 0 || STEP_WIDE <= 0) begin : g_zero_step
         $error("ctxp_lps_step: step constants must be positive");
      end
   endgenerate

   logic [SUM_W-1:0] step;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] reflected;
   logic             over;

   always_comb begin
      case (win_i)
         WIN_NARROW: step = SUM_W'(STEP_NARROW);
         WIN_MID:    step = SUM_W'(STEP_MID);
         default:    step = SUM_W'(STEP_WIDE);
      endcase
   end

   assign sum       = {1'b0, lgp_i} + step;
   assign over      = sum[SUM_W-1];
   assign reflected = MIRROR - sum;

   always_comb begin
      if (over) begin
         lgp_o     = reflected[PROB_W-1:0];
         mps_val_o = ~mps_val_i;
      end else begin
         lgp_o     = sum[PROB_W-1:0];
         mps_val_o = mps_val_i;
      end
   end

endmodule

// File: rtl/ctx_prob_adapt.sv
module ctx_prob_adapt
   import ctxp_pkg::*;
#(
   parameter int PROB_W      = 10,
   parameter int CYC_W       = 2,
   parameter int NARROW_MAX  = 1,
   parameter int MID_AGE     = 2,
   parameter int SH_NARROW   = 3,
   parameter int SH_MID      = 4,
   parameter int SH_WIDE     = 5,
   parameter int TAIL_EXTRA  = 2,
   parameter int STEP_NARROW = 197,
   parameter int STEP_MID    = 95,
   parameter int STEP_WIDE   = 46,
   parameter int DECAY_IMPL  = DECAY_SLICED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_is_mps,
   input  logic [9:0]        in_lgp,
   input  logic [1:0]        in_cyc,
   input  logic              in_mps_val,
   output logic              out_valid,
   output logic [9:0]        out_lgp,
   output logic [1:0]        out_cyc,
   output logic              out_mps_val
);
   localparam logic [PROB_W-1:0] LGP_INIT  = {PROB_W{1'b1}};
   localparam int                STEP_MAX  = (STEP_NARROW > STEP_MID) ?
                                             ((STEP_NARROW > STEP_WIDE) ? STEP_NARROW : STEP_WIDE) :
                                             ((STEP_MID > STEP_WIDE) ? STEP_MID : STEP_WIDE);
   localparam int                FLIP_FLOOR = (1 << PROB_W) - 1 - STEP_MAX;

   generate
      if (PROB_W != 10 || CYC_W != 2) begin : g_port_width
         $error("ctx_prob_adapt: port widths are fixed at 10 and 2 bits");
      end
   endgenerate

   win_e              win;
   logic [CYC_W-1:0]  age_next;
   logic [PROB_W-1:0] lgp_hit;
   logic [PROB_W-1:0] lgp_miss;
   logic              mps_miss;

   ctxp_window #(
      .CYC_W      (CYC_W),
      .NARROW_MAX (NARROW_MAX),
      .MID_AGE    (MID_AGE)
   ) u_window (
      .age_i      (in_cyc),
      .win_o      (win),
      .age_next_o (age_next)
   );

   ctxp_mps_decay #(
      .PROB_W     (PROB_W),
      .SH_NARROW  (SH_NARROW),
      .SH_MID     (SH_MID),
      .SH_WIDE    (SH_WIDE),
      .TAIL_EXTRA (TAIL_EXTRA),
      .IMPL       (DECAY_IMPL)
   ) u_decay (
      .lgp_i (in_lgp),
      .win_i (win),
      .lgp_o (lgp_hit)
   );

   ctxp_lps_step #(
      .PROB_W      (PROB_W),
      .STEP_NARROW (STEP_NARROW),
      .STEP_MID    (STEP_MID),
      .STEP_WIDE   (STEP_WIDE)
   ) u_step (
      .lgp_i     (in_lgp),
      .win_i     (win),
      .mps_val_i (in_mps_val),
      .lgp_o     (lgp_miss),
      .mps_val_o (mps_miss)
   );

   // Result register, loaded only on a strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_lgp     <= LGP_INIT;
         out_cyc     <= '0;
         out_mps_val <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_cyc     <= age_next;
            out_lgp     <= in_is_mps ? lgp_hit : lgp_miss;
            out_mps_val <= in_is_mps ? in_mps_val : mps_miss;
         end
      end
   end

   // R2: strobe follows the input strobe by one cycle
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R8: idle cycles leave the context untouched
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_lgp) && $stable(out_cyc) && $stable(out_mps_val)));

   // R4: age never goes back and is never zero after an update
   a_r4_age_advances: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_cyc != 2'd0) && (out_cyc >= $past(in_cyc)));

   // R5: a matching bin keeps the symbol and never raises the probability value
   a_r5_hit_decays: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_is_mps) |=>
         (out_mps_val == $past(in_mps_val)) && (out_lgp <= $past(in_lgp)));

   // R6 / R7: without a flip the value grows, with a flip it lands near full scale
   a_r7_miss_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_is_mps) |=>
         ((out_mps_val == $past(in_mps_val)) ? (out_lgp > $past(in_lgp))
                                             : (int'(out_lgp) >= FLIP_FLOOR)));

endmodule

// File: tb/ctx_prob_adapt_tb.sv
module ctx_prob_adapt_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic       in_is_mps;
   logic [9:0] in_lgp;
   logic [1:0] in_cyc;
   logic       in_mps_val;
   logic       out_valid;
   logic [9:0] out_lgp;
   logic [1:0] out_cyc;
   logic       out_mps_val;

   int  n_vec  = 0;
   int  n_bad  = 0;
   bit  done   = 1'b0;

   always #4 clk = ~clk;

   ctx_prob_adapt u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_is_mps   (in_is_mps),
      .in_lgp      (in_lgp),
      .in_cyc      (in_cyc),
      .in_mps_val  (in_mps_val),
      .out_valid   (out_valid),
      .out_lgp     (out_lgp),
      .out_cyc     (out_cyc),
      .out_mps_val (out_mps_val)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // Reference arithmetic from the requirements
   function automatic int win_of(input int age);
      if (age <= 1)      return 3;
      else if (age == 2) return 4;
      else               return 5;
   endfunction

   function automatic int step_of(input int w);
      if (w == 3)      return 197;
      else if (w == 4) return 95;
      else             return 46;
   endfunction

   int    e_lgp;
   int    e_cyc;
   int    e_mv;
   string e_tag;

   task automatic check_prev;
      chk("R2", "out_valid", int'(out_valid), 1);
      chk("R4", "out_cyc", int'(out_cyc), e_cyc);
      chk(e_tag, "out_lgp", int'(out_lgp), e_lgp);
      chk(e_tag, "out_mps_val", int'(out_mps_val), e_mv);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R2 watchdog: actual hung expected finished run");
         summary();
         $finish;
      end
   end

   initial begin
      bit have_prev = 1'b0;
      rst_n      = 1'b0;
      in_valid   = 1'b0;
      in_is_mps  = 1'b0;
      in_lgp     = '0;
      in_cyc     = '0;
      in_mps_val = 1'b0;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "out_lgp", int'(out_lgp), 1023);
      chk("R1", "out_cyc", int'(out_cyc), 0);
      chk("R1", "out_mps_val", int'(out_mps_val), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 after release with no strobe
      chk("R1", "out_valid idle", int'(out_valid), 0);
      chk("R1", "out_lgp idle", int'(out_lgp), 1023);
      chk("R1", "out_cyc idle", int'(out_cyc), 0);
      chk("R1", "out_mps_val idle", int'(out_mps_val), 0);

      // Exhaustive back-to-back sweep (R3, R4, R5, R6, R7)
      for (int p = 0; p < 1024; p++) begin
         for (int age = 0; age < 4; age++) begin
            for (int mv = 0; mv < 2; mv++) begin
               for (int hit = 0; hit < 2; hit++) begin
                  @(negedge clk);
                  if (have_prev) check_prev();
                  in_valid   = 1'b1;
                  in_lgp     = 10'(p);
                  in_cyc     = 2'(age);
                  in_mps_val = mv[0];
                  in_is_mps  = hit[0];
                  begin
                     int w;
                     int s;
                     w     = win_of(age);
                     e_cyc = (age == 3) ? 3 : age + 1;
                     if (hit != 0) begin
                        e_lgp = p - (p >> w) - (p >> (w + 2));
                        e_mv  = mv;
                        e_tag = "R3/R5";
                     end else begin
                        s = step_of(w);
                        if (p + s > 1023) begin
                           e_lgp = 2047 - (p + s);
                           e_mv  = 1 - mv;
                           e_tag = "R3/R7";
                        end else begin
                           e_lgp = p + s;
                           e_mv  = mv;
                           e_tag = "R3/R6";
                        end
                     end
                  end
                  have_prev = 1'b1;
               end
            end
         end
      end
      @(negedge clk);
      check_prev();

      // R8: strobe low, other inputs move
      in_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         in_lgp     = 10'(37 * k + 5);
         in_cyc     = 2'(k);
         in_mps_val = ~in_mps_val;
         in_is_mps  = k[0];
         @(negedge clk);
         chk("R2", "out_valid idle", int'(out_valid), 0);
         chk("R8", "out_lgp hold", int'(out_lgp), e_lgp);
         chk("R8", "out_cyc hold", int'(out_cyc), e_cyc);
         chk("R8", "out_mps_val hold", int'(out_mps_val), e_mv);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule